// File: doc/BRIEF.md
# Pitched Sample Playback Address Generator

This block walks one playback channel through a stored waveform. Each output tick (one pulse per output sample period) moves a 16.16 fixed-point position forward by a step that comes from a 10-bit frequency number and a signed 4-bit octave. When the integer part runs past the end point, the block folds it back so that playback continues inside the loop. The integer part becomes one or two byte reads from sample memory, and the fetched bytes are put together into a left-justified signed 16-bit sample.

Three storage formats are handled. Samples can be one byte each, two bytes each with the high byte first, or 12-bit samples packed in pairs into three bytes. The pitch is written in two parts. The octave and the top three frequency bits go into a staging register, and the new pitch takes effect only when the low seven frequency bits are written. While key-on is low the channel is silent and its position is held at sample 0. Ticks must be at least four clock cycles apart.

Top module: `pitch_sample_stepper`

## Requirements
- R1: With octave 1 and frequency number 0, the position advances by exactly one sample per accepted tick. In general the step is 2^(octave−1)·(1024+F)/1024 samples. The octave is 4-bit two's complement in −7..+7 and F is 0..1023.
- R2: Fractional steps accumulate across ticks. With octave −1 and F=0 each sample index is fetched on four consecutive ticks. With octave 0 and F=512 the fetched indices are 0,0,1,2,3,3,4.
- R3: A write to `pitch_hi_data` (octave in bits 6:3, F bits 9:7 in bits 2:0) does not change the pitch. The pitch changes only on the next write of F bits 6:0 to `pitch_lo_data`, which commits the staged high part together with the low part.
- R4: Format code 0 (8-bit): index n reads byte `start_addr+n`, and the output is that byte in bits 15:8 with bits 7:0 zero.
- R5: Format code 2 or 3 (16-bit): index n reads `start_addr+2n` as bits 15:8 and then `start_addr+2n+1` as bits 7:0.
- R6: Format code 1 (12-bit): with p=n/2 and b=`start_addr`+3p, an even n gives {byte b, high nibble of byte b+1, 4'h0}. An odd n gives {byte b+2, low nibble of byte b+1, 4'h0}.
- R7: When the integer position after a step exceeds `end_pt`, (`end_pt`−`loop_pt`) is subtracted from it. With loop 2, end 5 and a step of 1, the fetched indices are 0,1,2,3,4,5,3,4,5,3.
- R8: While `key_on` is low, `sample_out` is 0, no read is requested and ticks are ignored. The first tick after `key_on` rises fetches index 0. After reset the outputs are 0.
- R9: The tick edge issues the first read. The read data is taken two edges after each request. `sample_valid` pulses for one cycle: two cycles after the tick edge for 8-bit samples and three cycles after it otherwise. `rd_req` is never high for more than two cycles in a row.
- R10: `sample_out` changes only together with a `sample_valid` pulse, or when key-on is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per output sample period |
| key_on | input | 1 | Channel sounding; low holds position at 0 and output at 0 |
| start_addr | input | 22 | Byte address of sample 0 |
| loop_pt | input | 16 | Loop point in samples |
| end_pt | input | 16 | End point in samples |
| fmt | input | 2 | 0: 8-bit, 1: 12-bit packed, 2/3: 16-bit |
| pitch_hi_we | input | 1 | Strobe for the staged pitch high part |
| pitch_hi_data | input | 7 | {octave[3:0], F[9:7]} |
| pitch_lo_we | input | 1 | Strobe that commits the pitch |
| pitch_lo_data | input | 7 | F[6:0] |
| rd_req | output | 1 | Memory byte read request |
| rd_addr | output | 22 | Memory byte address |
| rd_data | input | 8 | Read data, taken two edges after the request edge |
| sample_out | output | 16 | Left-justified signed sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
A wrong step, whether from a bad shift, a lost commit or an early pitch change, shows on the very next tick as the wrong byte address, and therefore as the wrong sample, one tick earlier or later than expected. A bad loop fold appears only when the position crosses the end point, so the loop scenario reads sample values right across that boundary. Errors in nibble selection or byte order corrupt specific bits of `sample_out` on the same tick, so 12-bit tests use both even and odd indices. A fetch state machine that hangs or fires twice shows within three cycles as a missing or extra `sample_valid` pulse.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic [1:0] {
      FMT_8   = 2'd0,
      FMT_12  = 2'd1,
      FMT_16  = 2'd2,
      FMT_16X = 2'd3
   } pss_fmt_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_REQ0  = 2'd1,
      PH_DATA0 = 2'd2,
      PH_DATA1 = 2'd3
   } pss_phase_e;

   // combine two fetched bytes into a left-justified 16-bit sample
   function automatic logic [15:0] pss_join(pss_fmt_e f, logic odd,
                                            logic [7:0] b0, logic [7:0] b1);
      logic [3:0] nib;
      nib = odd ? b1[3:0] : b1[7:4];
      if (f == FMT_12) return {b0, nib, 4'h0};
      return {b0, b1};
   endfunction

endpackage

// File: rtl/pss_pitch_regs.sv
module pss_pitch_regs #(
   parameter int FNUM_W = 10,
   parameter int OCT_W  = 4,
   parameter int FLO_W  = 7,
   parameter int FRAC_W = 16,
   localparam int FHI_W  = FNUM_W - FLO_W,
   localparam int BIAS   = 2**(OCT_W-1) - 1,
   localparam int WIDE_W = FNUM_W + 1 + 2*BIAS,
   localparam int RSH    = BIAS + 1 + FNUM_W - FRAC_W,
   localparam int STEP_W = WIDE_W - RSH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hi_we,
   input  logic [OCT_W+FHI_W-1:0]  hi_data,
   input  logic                    lo_we,
   input  logic [FLO_W-1:0]        lo_data,
   output logic [STEP_W-1:0]       step
);

   generate
      if (FLO_W >= FNUM_W || FLO_W < 1) begin : g_bad_split
         $error("pss_pitch_regs: FLO_W must lie in 1..FNUM_W-1");
      end
      if (RSH < 0) begin : g_bad_frac
         $error("pss_pitch_regs: FRAC_W too wide for the shifter");
      end
   endgenerate

   logic [OCT_W+FHI_W-1:0] staged_q;
   logic [OCT_W-1:0]       oct_q;
   logic [FNUM_W-1:0]      fnum_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged_q <= '0;
         oct_q    <= '0;
         fnum_q   <= '0;
      end else begin
         if (hi_we) staged_q <= hi_data;
         if (lo_we) begin
            oct_q  <= staged_q[OCT_W+FHI_W-1:FHI_W];
            fnum_q <= {staged_q[FHI_W-1:0], lo_data};
         end
      end
   end

   // shift amount = octave + BIAS; the unused most negative code maps to 0
   logic [OCT_W-1:0] sh;
   always_comb begin
      sh = oct_q + OCT_W'(BIAS);
      if (oct_q == {1'b1, {(OCT_W-1){1'b0}}}) sh = '0;
   end

   logic [WIDE_W-1:0] stg [0:OCT_W];
   assign stg[0] = WIDE_W'({1'b1, fnum_q});

   genvar k;
   generate
      for (k = 0; k < OCT_W; k++) begin : g_shift
         assign stg[k+1] = sh[k] ? (stg[k] << (2**k)) : stg[k];
      end
   endgenerate

   logic [WIDE_W-1:0] wide_shr;
   assign wide_shr = stg[OCT_W] >> RSH;
   assign step     = wide_shr[STEP_W-1:0];

endmodule

// File: rtl/pss_phase_acc.sv
module pss_phase_acc #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 16,
   parameter int STEP_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [STEP_W-1:0] step,
   input  logic [INT_W-1:0]  loop_pt,
   input  logic [INT_W-1:0]  end_pt,
   output logic [INT_W-1:0]  pos_int
);

   localparam int POS_W = INT_W + FRAC_W;

   generate
      if (STEP_W > POS_W) begin : g_bad_step
         $error("pss_phase_acc: step wider than the position");
      end
   endgenerate

   logic [FRAC_W-1:0] pos_frac;
   logic [POS_W:0]    sum;
   logic [INT_W:0]    sum_int;
   logic [INT_W-1:0]  span;
   logic [INT_W:0]    folded;

   always_comb begin
      sum     = {1'b0, pos_int, pos_frac} + (POS_W+1)'(step);
      sum_int = sum[POS_W:FRAC_W];
      span    = end_pt - loop_pt;
      folded  = sum_int;
      if (sum_int > {1'b0, end_pt}) folded = sum_int - {1'b0, span};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pos_int  <= '0;
         pos_frac <= '0;
      end else if (advance) begin
         pos_int  <= folded[INT_W-1:0];
         pos_frac <= sum[FRAC_W-1:0];
      end
   end

endmodule

// File: rtl/pss_fetch.sv
module pss_fetch
   import pss_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int INT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_on,
   input  logic              tick,
   input  logic [1:0]        fmt,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [INT_W-1:0]  pos_int,
   output logic              accept,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic [15:0]       sample_out,
   output logic              sample_valid
);

   generate
      if (ADDR_W < INT_W + 2) begin : g_bad_addr
         $error("pss_fetch: address too narrow for packed 12-bit data");
      end
   endgenerate

   pss_fmt_e          fmt_in, fmt_q;
   pss_phase_e        ph;
   logic [ADDR_W-1:0] a0, a1, a1_q, pair3;
   logic              odd_q;
   logic [7:0]        byte0_q;

   assign fmt_in = pss_fmt_e'(fmt);
   assign accept = key_on && tick && (ph == PH_IDLE);

   always_comb begin
      pair3 = (ADDR_W'(pos_int >> 1) << 1) + ADDR_W'(pos_int >> 1);
      case (fmt_in)
         FMT_8: begin
            a0 = start_addr + ADDR_W'(pos_int);
            a1 = a0;
         end
         FMT_12: begin
            a0 = start_addr + pair3 + (pos_int[0] ? ADDR_W'(2) : ADDR_W'(0));
            a1 = start_addr + pair3 + ADDR_W'(1);
         end
         default: begin
            a0 = start_addr + (ADDR_W'(pos_int) << 1);
            a1 = a0 + ADDR_W'(1);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !key_on) begin
         ph           <= PH_IDLE;
         rd_req       <= 1'b0;
         rd_addr      <= '0;
         a1_q         <= '0;
         fmt_q        <= FMT_8;
         odd_q        <= 1'b0;
         byte0_q      <= '0;
         sample_out   <= '0;
         sample_valid <= 1'b0;
      end else begin
         sample_valid <= 1'b0;
         case (ph)
            PH_IDLE: if (tick) begin
               rd_req  <= 1'b1;
               rd_addr <= a0;
               a1_q    <= a1;
               fmt_q   <= fmt_in;
               odd_q   <= pos_int[0];
               ph      <= PH_REQ0;
            end
            PH_REQ0: begin
               rd_req  <= (fmt_q != FMT_8);
               rd_addr <= a1_q;
               ph      <= PH_DATA0;
            end
            PH_DATA0: begin
               rd_req  <= 1'b0;
               byte0_q <= rd_data;
               if (fmt_q == FMT_8) begin
                  sample_out   <= {rd_data, 8'h00};
                  sample_valid <= 1'b1;
                  ph           <= PH_IDLE;
               end else begin
                  ph <= PH_DATA1;
               end
            end
            default: begin
               sample_out   <= pss_join(fmt_q, odd_q, byte0_q, rd_data);
               sample_valid <= 1'b1;
               ph           <= PH_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/pitch_sample_stepper.sv
module pitch_sample_stepper #(
   parameter int ADDR_W = 22,
   parameter int INT_W  = 16,
   parameter int FRAC_W = 16,
   parameter int FNUM_W = 10,
   parameter int OCT_W  = 4,
   parameter int FLO_W  = 7,
   localparam int FHI_W  = FNUM_W - FLO_W,
   localparam int BIAS   = 2**(OCT_W-1) - 1,
   localparam int WIDE_W = FNUM_W + 1 + 2*BIAS,
   localparam int RSH    = BIAS + 1 + FNUM_W - FRAC_W,
   localparam int STEP_W = WIDE_W - RSH
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   key_on,
   input  logic [ADDR_W-1:0]      start_addr,
   input  logic [INT_W-1:0]       loop_pt,
   input  logic [INT_W-1:0]       end_pt,
   input  logic [1:0]             fmt,
   input  logic                   pitch_hi_we,
   input  logic [OCT_W+FHI_W-1:0] pitch_hi_data,
   input  logic                   pitch_lo_we,
   input  logic [FLO_W-1:0]       pitch_lo_data,
   output logic                   rd_req,
   output logic [ADDR_W-1:0]      rd_addr,
   input  logic [7:0]             rd_data,
   output logic [15:0]            sample_out,
   output logic                   sample_valid
);

   logic [STEP_W-1:0] step_w;
   logic [INT_W-1:0]  pos_int;
   logic              accept;

   pss_pitch_regs #(
      .FNUM_W(FNUM_W), .OCT_W(OCT_W), .FLO_W(FLO_W), .FRAC_W(FRAC_W)
   ) u_pitch (
      .clk(clk), .rst_n(rst_n),
      .hi_we(pitch_hi_we), .hi_data(pitch_hi_data),
      .lo_we(pitch_lo_we), .lo_data(pitch_lo_data),
      .step(step_w)
   );

   pss_phase_acc #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
   ) u_phase (
      .clk(clk), .rst_n(rst_n),
      .clear(!key_on), .advance(accept), .step(step_w),
      .loop_pt(loop_pt), .end_pt(end_pt),
      .pos_int(pos_int)
   );

   pss_fetch #(
      .ADDR_W(ADDR_W), .INT_W(INT_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .key_on(key_on), .tick(tick), .fmt(fmt),
      .start_addr(start_addr), .pos_int(pos_int),
      .accept(accept),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .sample_out(sample_out), .sample_valid(sample_valid)
   );

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int STEP_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic              key_on,
   input logic              rd_req,
   input logic [15:0]       sample_out,
   input logic              sample_valid,
   input logic              pitch_lo_we,
   input logic [STEP_W-1:0] step_w
);

   assert_keyoff_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !key_on |=> (sample_out == 16'h0000));

   assert_keyoff_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !key_on |=> !rd_req);

   assert_req_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && $past(rd_req)) |=> !rd_req);

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   assert_out_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sample_out) |-> (sample_valid || !$past(key_on)));

   assert_pitch_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(step_w) |-> $past(pitch_lo_we));

endmodule

bind pitch_sample_stepper pss_checker #(.STEP_W(STEP_W)) u_pss_chk (
   .clk(clk), .rst_n(rst_n), .key_on(key_on), .rd_req(rd_req),
   .sample_out(sample_out), .sample_valid(sample_valid),
   .pitch_lo_we(pitch_lo_we), .step_w(step_w)
);

// File: tb/pitch_sample_stepper_bench.sv
`timescale 1ns/1ps
module pitch_sample_stepper_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, key_on = 1'b0;
   logic [21:0] start_addr = 22'h000100;
   logic [15:0] loop_pt = 16'd0, end_pt = 16'hFFFF;
   logic [1:0]  fmt = 2'd0;
   logic        pitch_hi_we = 1'b0, pitch_lo_we = 1'b0;
   logic [6:0]  pitch_hi_data = '0, pitch_lo_data = '0;
   logic        rd_req;
   logic [21:0] rd_addr;
   logic [7:0]  rd_data = '0;
   logic [15:0] sample_out;
   logic        sample_valid;

   int checks = 0, failures = 0;
   bit done = 0;
   longint ref_pos = 0, ref_step = 0, staged_oct = 0, staged_fhi = 0;

   always #4 clk = ~clk;

   pitch_sample_stepper u_pitch_sample_stepper (
      .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on),
      .start_addr(start_addr), .loop_pt(loop_pt), .end_pt(end_pt), .fmt(fmt),
      .pitch_hi_we(pitch_hi_we), .pitch_hi_data(pitch_hi_data),
      .pitch_lo_we(pitch_lo_we), .pitch_lo_data(pitch_lo_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .sample_out(sample_out), .sample_valid(sample_valid)
   );

   function automatic logic [7:0] memb(longint a);
      return 8'(((a & 4095) * 37 + 11) & 255);
   endfunction

   always @(posedge clk) if (rd_req) rd_data <= memb(longint'(rd_addr));

   function automatic logic [15:0] exp_sample(int f, longint n);
      longint b;
      logic [7:0] m;
      case (f)
         0: return {memb(start_addr + n), 8'h00};
         1: begin
            b = start_addr + 3 * (n / 2);
            m = memb(b + 1);
            if (n % 2 == 0) return {memb(b), m[7:4], 4'h0};
            return {memb(b + 2), m[3:0], 4'h0};
         end
         default: return {memb(start_addr + 2*n), memb(start_addr + 2*n + 1)};
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_hi(int oct, int fnum);
      @(negedge clk);
      pitch_hi_data = {4'(oct), 3'(fnum >> 7)};
      pitch_hi_we = 1'b1;
      @(negedge clk);
      pitch_hi_we = 1'b0;
      staged_oct = oct; staged_fhi = (fnum >> 7) & 7;
   endtask

   task automatic write_lo(int fnum);
      longint f, m;
      @(negedge clk);
      pitch_lo_data = 7'(fnum);
      pitch_lo_we = 1'b1;
      @(negedge clk);
      pitch_lo_we = 1'b0;
      f = (staged_fhi << 7) | (fnum & 127);
      m = (1024 + f) * 64;
      ref_step = (staged_oct >= 1) ? (m << (staged_oct - 1)) : (m >> (1 - staged_oct));
   endtask

   task automatic set_pitch(int oct, int fnum);
      write_hi(oct, fnum);
      write_lo(fnum);
   endtask

   task automatic restart(int f);
      @(negedge clk);
      key_on = 1'b0; fmt = 2'(f);
      repeat (2) @(negedge clk);
      key_on = 1'b1;
      ref_pos = 0;
      @(negedge clk);
   endtask

   // one tick: checks the R9 timing and the sample against the reference position
   task automatic do_tick(string req);
      longint idx, si, sum;
      logic [15:0] e;
      int got;
      idx = ref_pos >> 16;
      e = exp_sample(int'(fmt), idx);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      got = 0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (sample_valid && got == 0) got = k;
      end
      chk(got == ((fmt == 2'd0) ? 2 : 3), "R9", "valid latency", got, (fmt == 2'd0) ? 2 : 3);
      chk(sample_out == e, req, $sformatf("sample idx %0d", idx), sample_out, e);
      sum = ref_pos + ref_step;
      si = sum >> 16;
      if (si > end_pt) si = si - (end_pt - loop_pt);
      ref_pos = ((si & 16'hFFFF) << 16) | (sum & 16'hFFFF);
   endtask

   task automatic t_reset();
      chk(sample_out == 0, "R8", "reset sample_out", sample_out, 0);
      chk(rd_req == 0, "R8", "reset rd_req", rd_req, 0);
      chk(sample_valid == 0, "R10", "reset sample_valid", sample_valid, 0);
   endtask

   task automatic t_unity_8bit();
      loop_pt = 0; end_pt = 16'hFFFF;
      set_pitch(1, 0);
      restart(0);
      for (int i = 0; i < 6; i++) do_tick("R1/R4");
      chk(ref_pos == (6 << 16), "R1", "position after 6 ticks", ref_pos, 6 << 16);
   endtask

   task automatic t_16bit();
      set_pitch(1, 0);
      restart(2);
      for (int i = 0; i < 4; i++) do_tick("R5");
      restart(3);
      do_tick("R5"); do_tick("R5");
   endtask

   task automatic t_12bit();
      set_pitch(1, 0);
      restart(1);
      for (int i = 0; i < 6; i++) do_tick("R6");
   endtask

   task automatic t_fraction();
      set_pitch(-1, 0);
      restart(0);
      for (int i = 0; i < 8; i++) do_tick("R2");
      chk(ref_pos == (2 << 16), "R2", "quarter step position", ref_pos, 2 << 16);
      set_pitch(0, 512);
      restart(0);
      for (int i = 0; i < 7; i++) do_tick("R2");
      set_pitch(7, 1023);
      restart(0);
      do_tick("R1"); do_tick("R1");
   endtask

   task automatic t_pitch_stage();
      set_pitch(1, 0);
      restart(0);
      write_hi(2, 0);
      for (int i = 0; i < 3; i++) do_tick("R3");
      chk(ref_pos == (3 << 16), "R3", "hi write alone keeps step", ref_pos, 3 << 16);
      write_lo(0);
      for (int i = 0; i < 3; i++) do_tick("R3");
      chk(ref_pos == (9 << 16), "R3", "commit doubles step", ref_pos, 9 << 16);
   endtask

   task automatic t_loop();
      loop_pt = 2; end_pt = 5;
      set_pitch(1, 0);
      restart(0);
      for (int i = 0; i < 10; i++) do_tick("R7");
      chk(ref_pos == (4 << 16), "R7", "position after wrap", ref_pos, 4 << 16);
      loop_pt = 0; end_pt = 16'hFFFF;
   endtask

   task automatic t_hold();
      logic [15:0] held;
      set_pitch(1, 0);
      restart(2);
      do_tick("R10");
      held = sample_out;
      repeat (6) @(negedge clk);
      chk(sample_out == held, "R10", "output held between ticks", sample_out, held);
   endtask

   task automatic t_keyoff();
      int reqs;
      set_pitch(1, 0);
      restart(0);
      do_tick("R8"); do_tick("R8"); do_tick("R8");
      key_on = 1'b0;
      @(negedge clk);
      chk(sample_out == 0, "R8", "key off clears output", sample_out, 0);
      reqs = 0;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int k = 0; k < 4; k++) begin
         if (rd_req || sample_valid) reqs++;
         @(negedge clk);
      end
      chk(reqs == 0, "R8", "tick ignored while off", reqs, 0);
      chk(sample_out == 0, "R8", "output stays 0 while off", sample_out, 0);
      key_on = 1'b1; ref_pos = 0;
      @(negedge clk);
      do_tick("R8");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_unity_8bit();
      t_16bit();
      t_12bit();
      t_fraction();
      t_pitch_stage();
      t_loop();
      t_hold();
      t_keyoff();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule